// File: doc/BRIEF.md
# Double-Precision to Signed 64-bit Integer Converter

This block takes a 64-bit IEEE-754 double and returns a signed 64-bit two's-complement integer. Each operation carries its own rounding mode, so results for different modes can be interleaved from one cycle to the next. The block raises three flags: invalid (the operand was infinity or NaN), integer overflow (the rounded value does not fit), and inexact (a fraction was discarded, or the value was out of range). It accepts one operand per cycle. Results appear two clock edges after the operand is sampled.

Inside, the block unpacks the operand into a 64-bit significand. The hidden bit sits at bit 63 and eleven zero guard bits fill the bottom. The first stage moves the significand to the integer boundary. For normal magnitudes this is a right shift that collects the discarded bits, left-aligned, into a sticky word. For very large exponents it is a left shift. The second stage rounds using the sticky word, checks the range, and applies the sign. When a value is out of range, the block still returns the low 64 bits of the wrapped result, so downstream logic always sees a defined value.

Top module: `dbl_to_int`

## Requirements
- R1: A zero operand of either sign returns 0 with all three flags clear.
- R2: An operand whose exponent field is all ones (infinity or NaN) returns 0 with the invalid flag set and the overflow and inexact flags clear.
- R3: An operand sampled with `in_valid` high produces exactly one result with `out_valid` high two rising edges later. While reset is active, and in any cycle where `out_valid` is low, all outputs read 0.
- R4: A finite operand whose value is an integer in [-2^63, 2^63-1] converts exactly, with no flags, in every rounding mode.
- R5: Rounding mode 0 (chopped) truncates toward zero. Any magnitude below 1, including subnormals, gives 0.
- R6: Rounding mode 2 (nearest) rounds to the nearest integer. An exact half goes to the even neighbour.
- R7: Rounding mode 1 (toward minus infinity) moves an inexact negative value one step further from zero. Rounding mode 3 (toward plus infinity) does the same for an inexact positive value. Each mode leaves values of the other sign truncated.
- R8: A rounded magnitude above 2^63-1 for a positive operand, or above 2^63 for a negative one, is out of range. The result is then the low 64 bits of the signed, rounded value, which is 0 once the binary point lies 64 or more places above the significand.
- R9: The overflow flag is raised only when the result is out of range and `in_ovf_trap_en` was high with that operand. When the enable is low, out-of-range results still give the same value and the inexact flag.
- R10: The inexact flag is set when a nonzero fraction was discarded or the result is out of range, and clear otherwise.
- R11: A negative operand's result is the two's-complement negation of the rounded magnitude, so -2^63 converts exactly with no flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | IEEE-754 double operand |
| in_rmode | input | 2 | Rounding mode: 0 chopped, 1 toward minus infinity, 2 nearest even, 3 toward plus infinity |
| in_ovf_trap_en | input | 1 | Allows the integer-overflow flag for this operand |
| out_valid | output | 1 | Result strobe, two edges after the operand |
| out_int | output | 64 | Signed integer result |
| out_invalid | output | 1 | Operand was infinity or NaN |
| out_iov | output | 1 | Result out of range, enable set |
| out_inexact | output | 1 | Fraction discarded or out of range |

## Verification
The checker follows every operand through the two-cycle pipeline and confirms the following properties:
- each strobe yields exactly one result;
- zero and non-finite operands give their fixed results;
- overflow never appears without its enable;
- overflow always implies inexact.

Other behaviour depends on rounding arithmetic: tie-breaking to even, the one-step moves of the directed modes, the boundary at -2^63 versus 2^63, and the wrapped low bits. Only the bench's scenarios can show these. The bench compares every result against a wide fixed-point model, for chosen operands and for a sweep of pseudo-random exponents spanning the tiny, in-range and overflow regions.

// File: rtl/dbl_to_int.sv
module dbl_to_int (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_op,
  input  logic [1:0]  in_rmode,
  input  logic        in_ovf_trap_en,
  output logic        out_valid,
  output logic [63:0] out_int,
  output logic        out_invalid,
  output logic        out_iov,
  output logic        out_inexact
);

  localparam logic [1:0]  RM_CHOP  = 2'd0;
  localparam logic [1:0]  RM_MINUS = 2'd1;
  localparam logic [1:0]  RM_NEAR  = 2'd2;
  localparam logic [1:0]  RM_PLUS  = 2'd3;
  localparam logic [10:0] EXP_HALF = 11'd1022;
  localparam logic [10:0] EXP_TOP  = 11'd1086;
  localparam logic [10:0] EXP_SPEC = 11'h7ff;
  localparam logic [63:0] HALF_WORD = 64'h8000_0000_0000_0000;

  // stage 1: unpack and align
  wire [10:0]  exp_a   = in_op[62:52];
  wire [63:0]  sig_a   = {exp_a != 11'd0, in_op[51:0], 11'b0};
  wire [10:0]  rdist   = EXP_TOP - exp_a;
  wire [10:0]  ldist   = exp_a - EXP_TOP;
  wire [127:0] rwide   = {sig_a, 64'b0} >> rdist[5:0];
  wire         spec_a  = exp_a == EXP_SPEC;
  wire         zero_a  = in_op[62:0] == 63'd0;

  logic [63:0] int_a, stk_a;
  logic        big_a;

  always_comb begin
    big_a = 1'b0;
    if (exp_a < EXP_HALF) begin
      int_a = '0;
      stk_a = 64'd1;
    end else if (exp_a == EXP_HALF) begin
      int_a = '0;
      stk_a = sig_a;
    end else if (exp_a <= EXP_TOP) begin
      int_a = rwide[127:64];
      stk_a = rwide[63:0];
    end else begin
      big_a = 1'b1;
      stk_a = '0;
      int_a = (ldist > 11'd63) ? 64'd0 : (sig_a << ldist[5:0]);
    end
  end

  logic        s1_valid, s1_sign, s1_spec, s1_zero, s1_big, s1_te;
  logic [1:0]  s1_rm;
  logic [63:0] s1_int, s1_stk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_spec  <= 1'b0;
      s1_zero  <= 1'b0;
      s1_big   <= 1'b0;
      s1_te    <= 1'b0;
      s1_rm    <= RM_CHOP;
      s1_int   <= '0;
      s1_stk   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sign <= in_op[63];
        s1_spec <= spec_a;
        s1_zero <= zero_a;
        s1_big  <= big_a;
        s1_te   <= in_ovf_trap_en;
        s1_rm   <= in_rmode;
        s1_int  <= int_a;
        s1_stk  <= stk_a;
      end
    end
  end

  // stage 2: round, range check, sign
  wire stk_nz = |s1_stk;
  wire tie    = s1_stk == HALF_WORD;

  logic inc;
  always_comb begin
    case (s1_rm)
      RM_NEAR:  inc = s1_stk[63];
      RM_PLUS:  inc = !s1_sign && stk_nz;
      RM_MINUS: inc = s1_sign && stk_nz;
      default:  inc = 1'b0;
    endcase
  end

  wire [64:0] sum   = {1'b0, s1_int} + 65'd1;
  wire        wrap  = inc && sum[64];
  wire [63:0] mag   = inc ? {sum[63:1], sum[0] & ~((s1_rm == RM_NEAR) && tie)} : s1_int;
  wire        range = s1_sign ? (mag[63] && (|mag[62:0])) : mag[63];
  wire        ovf   = s1_big || wrap || range;
  wire [63:0] res   = s1_sign ? (~mag + 64'd1) : mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_iov     <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid   <= s1_valid;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_iov     <= 1'b0;
      out_inexact <= 1'b0;
      if (s1_valid) begin
        if (s1_spec) begin
          out_invalid <= 1'b1;
        end else if (!s1_zero) begin
          out_int     <= res;
          out_iov     <= ovf && s1_te;
          out_inexact <= ovf || stk_nz;
        end
      end
    end
  end

endmodule

// File: rtl/dbl_to_int_chk.sv
module dbl_to_int_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_op,
  input logic        in_ovf_trap_en,
  input logic        out_valid,
  input logic [63:0] out_int,
  input logic        out_invalid,
  input logic        out_iov,
  input logic        out_inexact
);

  // R1
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op[62:0] == 63'd0 |-> ##2
      (out_valid && out_int == 64'd0 && !out_invalid && !out_iov && !out_inexact));

  // R2
  special_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op[62:52] == 11'h7ff |-> ##2
      (out_valid && out_invalid && out_int == 64'd0 && !out_iov && !out_inexact));

  // R3
  strobe_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_int == 64'd0 && !out_invalid && !out_iov && !out_inexact));

  // R9
  trap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ovf_trap_en |-> ##2 !out_iov);

  // R10
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_iov |-> out_inexact);

endmodule

bind dbl_to_int dbl_to_int_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .in_ovf_trap_en(in_ovf_trap_en), .out_valid(out_valid), .out_int(out_int),
  .out_invalid(out_invalid), .out_iov(out_iov), .out_inexact(out_inexact)
);

// File: tb/dbl_to_int_test.sv
module dbl_to_int_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] v;
    logic        inv;
    logic        iov;
    logic        inx;
  } res_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_op = '0;
  logic [1:0]  in_rmode = '0;
  logic        in_ovf_trap_en = 1'b0;
  logic        out_valid;
  logic [63:0] out_int;
  logic        out_invalid, out_iov, out_inexact;

  res_t  exp_q[$];
  string tag_q[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbl_to_int uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_rmode(in_rmode), .in_ovf_trap_en(in_ovf_trap_en),
    .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
    .out_iov(out_iov), .out_inexact(out_inexact)
  );

  function automatic res_t model(logic [63:0] op, logic [1:0] rm, logic te);
    logic s, nz, gt, eq, up, ovf;
    int e;
    logic [127:0] full, ip, rem, half, mag;
    res_t r;
    r = '0;
    s = op[63];
    if (op[62:52] == 11'h7ff) begin r.inv = 1'b1; return r; end
    if (op[62:0] == 63'd0) return r;
    full = {75'b0, op[62:52] != 11'd0, op[51:0]};
    e = int'(op[62:52]) - 1075;
    ovf = 0; nz = 0; gt = 0; eq = 0; ip = '0;
    if (e >= 64) ovf = 1;
    else if (e >= 0) ip = full << e;
    else if (e <= -60) nz = 1;
    else begin
      ip   = full >> (-e);
      rem  = full & ((128'd1 << (-e)) - 128'd1);
      half = 128'd1 << (-e - 1);
      nz = rem != 0; gt = rem > half; eq = rem == half;
    end
    case (rm)
      2'd0: up = 0;
      2'd1: up = s && nz;
      2'd2: up = gt || (eq && ip[0]);
      default: up = !s && nz;
    endcase
    mag = ip + {127'b0, up};
    if (s ? (mag > 128'h8000_0000_0000_0000) : (mag >= 128'h8000_0000_0000_0000)) ovf = 1;
    r.v   = s ? (~mag[63:0] + 64'd1) : mag[63:0];
    r.iov = ovf && te;
    r.inx = ovf || nz;
    return r;
  endfunction

  task automatic send(input logic [63:0] op, input logic [1:0] rm, input logic te, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_rmode = rm; in_ovf_trap_en = te;
    exp_q.push_back(model(op, rm, te));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic all_modes(input logic [63:0] op, input logic te, input string tag);
    for (int m = 0; m < 4; m++) send(op, 2'(m), te, tag);
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      res_t  x;
      string t;
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3: unexpected result %h, expected none", out_int);
      end else begin
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_int !== x.v || out_invalid !== x.inv || out_iov !== x.iov || out_inexact !== x.inx) begin
          n_fail++;
          $display("FAIL %s: got %h inv=%b iov=%b inx=%b, expected %h inv=%b iov=%b inx=%b",
                   t, out_int, out_invalid, out_iov, out_inexact, x.v, x.inv, x.iov, x.inx);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    logic [63:0] lf;
    repeat (3) @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0 || out_int !== 64'd0 || out_invalid !== 1'b0 || out_iov !== 1'b0 || out_inexact !== 1'b0) begin
      n_fail++;
      $display("FAIL R3: reset outputs %b %h, expected 0 0", out_valid, out_int);
    end
    rst_n = 1'b1;
    idle(2);

    // R1 zeros
    all_modes(64'h0000_0000_0000_0000, 1, "R1");
    send(64'h8000_0000_0000_0000, 2'd3, 1, "R1");
    // R2 infinities and NaNs
    send(64'h7FF0_0000_0000_0000, 2'd2, 1, "R2");
    send(64'hFFF0_0000_0000_0000, 2'd0, 1, "R2");
    send(64'h7FF8_0000_0000_0001, 2'd1, 1, "R2");
    idle(3);
    // R4 exact integers
    all_modes(64'h3FF0_0000_0000_0000, 1, "R4");
    all_modes(64'h4330_0000_0000_0001, 1, "R4");
    all_modes(64'h43DF_FFFF_FFFF_FFFF, 1, "R4");
    // R5 chopped and tiny values
    send(64'h4004_0000_0000_0000, 2'd0, 1, "R5");
    send(64'hC00C_0000_0000_0000, 2'd0, 1, "R5");
    send(64'h3FE8_0000_0000_0000, 2'd0, 1, "R5");
    all_modes(64'h0000_0000_0000_0001, 1, "R5");
    all_modes(64'h81A5_6E1F_C2F8_F359, 1, "R5");
    // R6 nearest and ties
    send(64'h4004_0000_0000_0000, 2'd2, 1, "R6");
    send(64'h400C_0000_0000_0000, 2'd2, 1, "R6");
    send(64'h3FE0_0000_0000_0000, 2'd2, 1, "R6");
    send(64'h3FF8_0000_0000_0000, 2'd2, 1, "R6");
    send(64'hC004_0000_0000_0000, 2'd2, 1, "R6");
    send(64'h3FE8_0000_0000_0000, 2'd2, 1, "R6");
    idle(1);
    // R7 directed
    all_modes(64'h3FE8_0000_0000_0000, 1, "R7");
    all_modes(64'hBFE8_0000_0000_0000, 1, "R7");
    all_modes(64'hC004_0000_0000_0000, 1, "R7");
    // R8 and R11 range edges
    send(64'h43E0_0000_0000_0000, 2'd0, 1, "R8");
    send(64'hC3E0_0000_0000_0000, 2'd2, 1, "R11");
    send(64'hC3E0_0000_0000_0001, 2'd0, 1, "R8");
    send(64'h43F0_0000_0000_0000, 2'd3, 1, "R8");
    send(64'h7FEF_FFFF_FFFF_FFFF, 2'd2, 1, "R8");
    send(64'h43E8_0000_0000_0000, 2'd1, 1, "R8");
    // R9 enable low: value and inexact stay, overflow flag suppressed
    send(64'h43E0_0000_0000_0000, 2'd0, 0, "R9");
    send(64'hC3F0_0000_0000_0001, 2'd1, 0, "R9");
    // R10 and R11 inexact and negation
    send(64'hC059_0CCC_CCCC_CCCD, 2'd0, 0, "R10");
    send(64'hBFF0_0000_0000_0000, 2'd2, 0, "R11");
    idle(2);

    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] op;
      lf = lf ^ (lf << 13);
      lf = lf ^ (lf >> 7);
      lf = lf ^ (lf << 17);
      op = {lf[63], 11'(1000 + (lf[46:40] % 7'd100)), lf[51:0]};
      send(op, lf[39:38], lf[37], "R10");
      if (lf[5:3] == 3'd0) idle(1);
    end
    idle(1);
    while (exp_q.size() != 0) @(negedge clk);
    idle(3);
    report();
  end
endmodule